// File: doc/BRIEF.md
# Rotating Delay-Feedback Butterfly Stage

This block is the second butterfly of a radix-2² single-path delay-feedback FFT stage pair. It takes one complex sample per valid cycle and keeps a feedback line whose length is half the distance of the stage before it (N/4 for the first pair). Two bits from the shared synchronisation counter steer it. `sel_bf` chooses between filling the line and computing the two-point butterfly. `sel_rot` chooses the quarter of the window in which the incoming sample is first turned by −j.

The −j turn uses no multiplier. A commutator exchanges the real and imaginary parts, and the add/subtract units flip direction on the imaginary lane, so no separate negation is needed. The sum goes forward. The difference goes back into the line and leaves it during the next fill half. The parameter `HALVE` selects the output format. With `HALVE = 0` the output is one bit wider than the input. With `HALVE = 1` the output is floor(value/2) at the input width.

Top module: `sdf_rot_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_re`/`out_im` are 0, and the feedback line holds zeros.
- R2: On a valid sample with `sel_bf` = 0, the registered output is the value that left the feedback line. This is the difference stored DIST valid samples earlier, or zero for the first DIST samples after reset. The incoming sample, sign-extended, enters the line.
- R3: On a valid sample x(n) with `sel_bf` = 1 and `sel_rot` = 0, the output is x(n−DIST) + x(n). The difference x(n−DIST) − x(n) enters the line and comes out DIST valid samples later.
- R4: On a valid sample with `sel_bf` = 1 and `sel_rot` = 1, the sample is replaced by −j·x before the butterfly. The real part becomes the input imaginary part, and the imaginary part becomes the negated input real part.
- R5: The most negative input value (−2^(DW−1)), whether rotated or not, gives exact results with no wraparound at the internal width DW+1.
- R6: `out_valid` equals `in_valid` of the previous cycle, and a result appears exactly one clock after its sample is accepted.
- R7: A cycle with `in_valid` = 0 does not advance the feedback line, and the outputs keep their previous values whatever the data and select inputs are.
- R8: With `HALVE` = 0 the outputs are DW+1 bits wide and carry the full value. With `HALVE` = 1 they are DW bits wide and carry the value arithmetically shifted right by one.
- R9: `sel_rot` has no effect while `sel_bf` = 0. A sample presented in that quarter is stored unrotated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| sel_bf | input | 1 | Counter bit: 0 = fill the line, 1 = butterfly |
| sel_rot | input | 1 | Counter bit: with `sel_bf`, enables the −j turn |
| in_re | input | DW | Sample real part, two's complement |
| in_im | input | DW | Sample imaginary part, two's complement |
| out_valid | output | 1 | Result present |
| out_re | output | DW+1 or DW | Result real part |
| out_im | output | DW+1 or DW | Result imaginary part |

## Verification
The stream is driven with the counter bits cycling through all four quarters of a 4·DIST window. A directed first stretch puts full-scale positive and negative values into every quarter. In the rotated quarter this separates a correct swap-and-negate from a missing, mirrored or wrapping one, and in the third quarter it shows whether the rotate bit leaks into the fill half. Random samples with random idle gaps follow. They tell a line that advances only on valid apart from one that slips or counts idle cycles, and they compare the full-width and the halved outputs against one windowed reference formula.

// File: rtl/sdf_rot_pkg.sv
package sdf_rot_pkg;

   // What the stage does with the sample present this cycle
   typedef enum logic [1:0] {
      OP_LOAD    = 2'd0,   // fill half: sample into line, line head out
      OP_BFLY    = 2'd1,   // butterfly, sample as is
      OP_BFLY_RT = 2'd2    // butterfly, sample turned by -j first
   } stage_op_e;

   function automatic stage_op_e op_decode(input logic bf, input logic rt);
      if (!bf)     return OP_LOAD;
      else if (rt) return OP_BFLY_RT;
      else         return OP_BFLY;
   endfunction

endpackage

// File: rtl/sdf_rot_feedback.sv
module sdf_rot_feedback #(
   parameter int W     = 13,
   parameter int DEPTH = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv,
   input  logic signed [W-1:0] din_re,
   input  logic signed [W-1:0] din_im,
   output logic signed [W-1:0] dout_re,
   output logic signed [W-1:0] dout_im
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("sdf_rot_feedback: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic signed [W-1:0] q_re, q_im;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_re <= '0;
            q_im <= '0;
         end else if (adv) begin
            q_re <= din_re;
            q_im <= din_im;
         end
      end
      assign dout_re = q_re;
      assign dout_im = q_im;
   end else begin : g_chain
      logic signed [W-1:0] sr_re [DEPTH];
      logic signed [W-1:0] sr_im [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
               sr_re[k] <= '0;
               sr_im[k] <= '0;
            end
         end else if (adv) begin
            sr_re[0] <= din_re;
            sr_im[0] <= din_im;
            for (int k = 1; k < DEPTH; k++) begin
               sr_re[k] <= sr_re[k-1];
               sr_im[k] <= sr_im[k-1];
            end
         end
      end
      assign dout_re = sr_re[DEPTH-1];
      assign dout_im = sr_im[DEPTH-1];
   end

endmodule

// File: rtl/sdf_rot_addsub.sv
module sdf_rot_addsub #(
   parameter int W = 13
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   input  logic                sub,
   output logic signed [W-1:0] y
);
   assign y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/sdf_rot_bfly.sv
module sdf_rot_bfly #(
   parameter int W = 13
) (
   input  logic signed [W-1:0] a_re,
   input  logic signed [W-1:0] a_im,
   input  logic signed [W-1:0] x_re,
   input  logic signed [W-1:0] x_im,
   input  logic                rot,
   output logic signed [W-1:0] sum_re,
   output logic signed [W-1:0] sum_im,
   output logic signed [W-1:0] diff_re,
   output logic signed [W-1:0] diff_im
);

   // Commutator: the turned sample is (x_im, -x_re); the minus sign is
   // folded into the direction of the imaginary add/subtract lanes.
   logic signed [W-1:0] p_re, p_im;
   assign p_re = rot ? x_im : x_re;
   assign p_im = rot ? x_re : x_im;

   localparam int LANES = 4;
   logic signed [W-1:0] opa [LANES];
   logic signed [W-1:0] opb [LANES];
   logic                dir [LANES];
   logic signed [W-1:0] res [LANES];

   // lane 0: sum real, 1: sum imag, 2: diff real, 3: diff imag
   always_comb begin
      opa[0] = a_re; opb[0] = p_re; dir[0] = 1'b0;
      opa[1] = a_im; opb[1] = p_im; dir[1] = rot;
      opa[2] = a_re; opb[2] = p_re; dir[2] = 1'b1;
      opa[3] = a_im; opb[3] = p_im; dir[3] = ~rot;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sdf_rot_addsub #(.W(W)) u_as (
         .a   (opa[g]),
         .b   (opb[g]),
         .sub (dir[g]),
         .y   (res[g])
      );
   end

   assign sum_re  = res[0];
   assign sum_im  = res[1];
   assign diff_re = res[2];
   assign diff_im = res[3];

endmodule

// File: rtl/sdf_rot_outfmt.sv
module sdf_rot_outfmt #(
   parameter int IW    = 13,
   parameter bit HALVE = 1'b0,
   localparam int OW   = HALVE ? IW - 1 : IW
) (
   input  logic signed [IW-1:0] v,
   output logic signed [OW-1:0] y
);
   if (HALVE) begin : g_half
      assign y = $signed(v[IW-1:1]);
   end else begin : g_full
      assign y = v;
   end
endmodule

// File: rtl/sdf_rot_stage.sv
module sdf_rot_stage
   import sdf_rot_pkg::*;
#(
   parameter int  DW    = 12,
   parameter int  DIST  = 4,
   parameter bit  HALVE = 1'b0,
   localparam int IW    = DW + 1,
   localparam int OW    = HALVE ? DW : DW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 sel_bf,
   input  logic                 sel_rot,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 out_valid,
   output logic signed [OW-1:0] out_re,
   output logic signed [OW-1:0] out_im
);

   if (DW < 2) begin : g_bad_dw
      $error("sdf_rot_stage: DW must be at least 2");
   end
   if (DIST < 1 || (DIST & (DIST - 1)) != 0) begin : g_bad_dist
      $error("sdf_rot_stage: DIST must be a power of two");
   end

   stage_op_e op;
   logic      compute, rot;
   assign op      = op_decode(sel_bf, sel_rot);
   assign compute = (op != OP_LOAD);
   assign rot     = (op == OP_BFLY_RT);

   // one guard bit so a negated full-scale value does not wrap
   logic signed [IW-1:0] x_re, x_im;
   assign x_re = IW'(in_re);
   assign x_im = IW'(in_im);

   logic signed [IW-1:0] head_re, head_im, fb_re, fb_im;
   logic signed [IW-1:0] sum_re, sum_im, diff_re, diff_im;
   logic signed [IW-1:0] pick_re, pick_im;
   logic signed [OW-1:0] fmt_re, fmt_im;

   sdf_rot_feedback #(.W(IW), .DEPTH(DIST)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (in_valid),
      .din_re  (fb_re),
      .din_im  (fb_im),
      .dout_re (head_re),
      .dout_im (head_im)
   );

   sdf_rot_bfly #(.W(IW)) u_bfly (
      .a_re    (head_re),
      .a_im    (head_im),
      .x_re    (x_re),
      .x_im    (x_im),
      .rot     (rot),
      .sum_re  (sum_re),
      .sum_im  (sum_im),
      .diff_re (diff_re),
      .diff_im (diff_im)
   );

   assign fb_re   = compute ? diff_re : x_re;
   assign fb_im   = compute ? diff_im : x_im;
   assign pick_re = compute ? sum_re  : head_re;
   assign pick_im = compute ? sum_im  : head_im;

   sdf_rot_outfmt #(.IW(IW), .HALVE(HALVE)) u_fmt_re (.v(pick_re), .y(fmt_re));
   sdf_rot_outfmt #(.IW(IW), .HALVE(HALVE)) u_fmt_im (.v(pick_im), .y(fmt_im));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_re <= fmt_re;
            out_im <= fmt_im;
         end
      end
   end

   // ---------------- assertions ----------------
   localparam int XW = IW + 2;
   logic signed [XW-1:0] e_sr, e_si, e_dr, e_di, e_hr, e_hi, e_xr, e_xi;
   assign e_sr = XW'(sum_re);
   assign e_si = XW'(sum_im);
   assign e_dr = XW'(diff_re);
   assign e_di = XW'(diff_im);
   assign e_hr = XW'(head_re);
   assign e_hi = XW'(head_im);
   assign e_xr = XW'(in_re);
   assign e_xi = XW'(in_im);

   // R2/R3: the two butterfly outputs are centred on the line head
   a_r2_pair_centre: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_bf) |-> ((e_sr + e_dr) == (e_hr + e_hr)) && ((e_si + e_di) == (e_hi + e_hi)));

   // R3: unturned sample spreads the pair by twice itself
   a_r3_plain_spread: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_bf && !sel_rot) |-> ((e_sr - e_dr) == (e_xr + e_xr)) && ((e_si - e_di) == (e_xi + e_xi)));

   // R4/R5: turned sample (x_im, -x_re) at full precision
   a_r4_rot_spread: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_bf && sel_rot) |-> ((e_sr - e_dr) == (e_xi + e_xi)) && ((e_si - e_di) == -(e_xr + e_xr)));

   // R6: one-cycle valid latency
   a_r6_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r6_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R7: idle cycle keeps the outputs
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_re) && $stable(out_im)));

endmodule

// File: tb/sdf_rot_stage_test.sv
module sdf_rot_stage_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 12;
   localparam int DIST = 4;
   localparam int WIN  = 4 * DIST;
   localparam int NS   = 600;
   localparam int NDIR = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, sel_bf = 1'b0, sel_rot = 1'b0;
   logic signed [DW-1:0] in_re = '0, in_im = '0;
   logic out_valid, outh_valid;
   logic signed [DW:0]   out_re, out_im;
   logic signed [DW-1:0] outh_re, outh_im;

   int xr [NS];
   int xi [NS];
   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdf_rot_stage #(.DW(DW), .DIST(DIST), .HALVE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_bf(sel_bf), .sel_rot(sel_rot),
      .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_re(out_re), .out_im(out_im));

   sdf_rot_stage #(.DW(DW), .DIST(DIST), .HALVE(1'b1)) uut_half (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_bf(sel_bf), .sel_rot(sel_rot),
      .in_re(in_re), .in_im(in_im), .out_valid(outh_valid), .out_re(outh_re), .out_im(outh_im));

   function automatic bit q_bf(int n);  return ((n % WIN) / DIST) % 2 == 1; endfunction
   function automatic bit q_rt(int n);  return ((n % WIN) / (2*DIST)) % 2 == 1; endfunction

   // sample after the optional -j turn
   function automatic int t_re(int n); return (q_bf(n) && q_rt(n)) ? xi[n] : xr[n]; endfunction
   function automatic int t_im(int n); return (q_bf(n) && q_rt(n)) ? -xr[n] : xi[n]; endfunction

   function automatic int exp_re(int n);
      if (q_bf(n))   return xr[n-DIST] + t_re(n);
      if (n < DIST)  return 0;
      return xr[n-2*DIST] - t_re(n-DIST);
   endfunction
   function automatic int exp_im(int n);
      if (q_bf(n))   return xi[n-DIST] + t_im(n);
      if (n < DIST)  return 0;
      return xi[n-2*DIST] - t_im(n-DIST);
   endfunction

   function automatic string tag_of(int n);
      if (q_bf(n) && q_rt(n)) return (xr[n] == -2048 || xi[n] == -2048) ? "R5" : "R4";
      if (q_bf(n))            return "R3";
      if (q_rt(n))            return "R9";
      return "R2";
   endfunction

   task automatic chk(string tag, int n, int gr, int gi, int er, int ei);
      n_tests++;
      if (gr != er || gi != ei) begin
         n_fail++;
         $display("FAIL %s n=%0d got re=%0d im=%0d expected re=%0d im=%0d", tag, n, gr, gi, er, ei);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int seed_dummy;
      int last_r, last_i, last_hr, last_hi;
      seed_dummy = $urandom(32'd4242);
      last_r = 0; last_i = 0; last_hr = 0; last_hi = 0;

      for (int n = 0; n < NS; n++) begin
         if (n < WIN) begin
            xr[n] = (n % 3 == 0) ? -2048 : ((n % 3 == 1) ? 2047 : n*37 - 300);
            xi[n] = (n % 2 == 1) ? -2048 : 2047 - n;
         end else if (n < NDIR) begin
            xr[n] = ((n / 2) % 2 == 1) ? 1500 : -1500;
            xi[n] = (n % 2 == 1) ? -777 : 777;
         end else begin
            xr[n] = int'($urandom % 4096) - 2048;
            xi[n] = int'($urandom % 4096) - 2048;
         end
      end

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", -1, int'(out_valid), int'(outh_valid), 0, 0);
      chk("R1", -1, int'(out_re), int'(out_im), 0, 0);
      chk("R1", -1, int'(outh_re), int'(outh_im), 0, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int n = 0; n < NS; n++) begin
         if (n == 5 || n == 21 || (n >= NDIR && ($urandom % 4) == 0)) begin
            // R7: idle cycle with junk on the data and select pins
            in_valid = 1'b0;
            sel_bf   = 1'($urandom);
            sel_rot  = 1'($urandom);
            in_re    = DW'($urandom);
            in_im    = DW'($urandom);
            @(negedge clk);
            chk("R7", n, int'(out_valid), int'(outh_valid), 0, 0);
            chk("R7", n, int'(out_re), int'(out_im), last_r, last_i);
            chk("R7", n, int'(outh_re), int'(outh_im), last_hr, last_hi);
         end
         in_valid = 1'b1;
         sel_bf   = q_bf(n);
         sel_rot  = q_rt(n);
         in_re    = DW'(xr[n]);
         in_im    = DW'(xi[n]);
         @(negedge clk);
         last_r  = exp_re(n);
         last_i  = exp_im(n);
         last_hr = last_r >>> 1;
         last_hi = last_i >>> 1;
         chk("R6", n, int'(out_valid), int'(outh_valid), 1, 1);
         chk(tag_of(n), n, int'(out_re), int'(out_im), last_r, last_i);
         chk("R8", n, int'(outh_re), int'(outh_im), last_hr, last_hi);
      end

      in_valid = 1'b0;
      @(negedge clk);
      chk("R6", NS, int'(out_valid), int'(outh_valid), 0, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule